// File: doc/BRIEF.md
# I2C Bus Address Scanner

This block walks an I2C port through every possible device address and reports which ones answer. A scan is requested with a single-cycle `startReq`. The scanner first looks at the two bus lines. If either line is low, the scan is refused at once: no command reaches the master, and the observed line levels are captured and flagged. If the bus is idle, the scanner takes the port lock and drives a byte-level I2C master through one short read transaction per address. It skips any register offset and reads a single byte.

Each probe is a sequence of three commands: a START with the address in read form, a one-byte read, and a STOP. An address counts as present only when all three commands complete cleanly. A present address is offered on a valid/ready stream. The scanner does not move on to the next probe until that stream accepts it, so no result can be lost to back-pressure. A keep-alive pulse goes out at every address step, so a long scan cannot trip a system watchdog. When the last address has been handled, a done pulse is raised and the port lock is released.

Top module: `i2c_addr_scanner`

## Requirements
- R1: On `startReq` with `sdaIn` or `sclIn` low, the scanner raises `busyAbort` for exactly one cycle (the cycle after the request), issues no master command and does not assert `portLock`.
- R2: On such a refused request, `lineLevels` holds the sampled lines, with bit 1 = SDA and bit 0 = SCL, until the next refusal.
- R3: With both lines high, probe addresses run from 0x00 to 0xFE in steps of 2, in rising order. `mstAddr` carries the probe address with bit 0 set, which marks the read direction.
- R4: Each probe issues, in order, command 0 (START plus address), command 1 (read one byte and NACK it) and command 2 (STOP). No write command exists. A command is taken when `mstCmdValid` and `mstCmdReady` are both high.
- R5: An address is reported only if none of its three responses carries `mstRspErr` (NACK) or `mstRspTimeout`. After a failed response, no further command is issued for that address.
- R6: `wdKick` pulses once per address step, before that address's START command, for 128 pulses per scan.
- R7: `portLock` is high from the cycle after an accepted request through the `scanDone` cycle, and low afterwards.
- R8: While `foundValid` is high without `foundReady`, `foundAddr` stays stable and no master command is issued.
- R9: `scanDone` is a single-cycle pulse, raised once after the final address has been handled.
- R10: After reset, all command, stream, lock, pulse and line-level outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Sampled clock line level |
| sdaIn | input | 1 | Sampled data line level |
| startReq | input | 1 | Scan request pulse |
| mstCmdValid | output | 1 | Command offered to the byte master |
| mstCmdReady | input | 1 | Master takes the command |
| mstCmd | output | 2 | 0 start+address, 1 read byte with NACK, 2 stop |
| mstAddr | output | 8 | Address byte with read bit set |
| mstRspValid | input | 1 | Master finished the last command |
| mstRspErr | input | 1 | Last command was NACKed |
| mstRspTimeout | input | 1 | Last command timed out |
| portLock | output | 1 | Port held for the scan |
| wdKick | output | 1 | Keep-alive pulse per address step |
| foundValid | output | 1 | A responding address is offered |
| foundReady | input | 1 | Consumer takes the address |
| foundAddr | output | 8 | Responding address, even form |
| busyAbort | output | 1 | Scan refused because the bus was not idle |
| lineLevels | output | 2 | Line levels captured at refusal {SDA, SCL} |
| scanDone | output | 1 | End-of-scan pulse |

## Verification
The bench aims at the address boundaries 0x00 and 0xFE. A counter that stopped early or wrapped would lose the top address or probe 0x00 twice. Failures are placed in each of the three probe phases: a NACK at START, a timeout on the read and an error on the STOP. A design that reported on any partial success, or kept issuing commands after an error, would produce an extra found address or an unexpected command. The bench also holds back `foundReady` and `mstCmdReady` on irregular cycles, which catches a stream that drops its data or starts the next probe while a result is still waiting. Finally, it refuses scans with each of the two lines held low, which catches swapped level bits and any stray bus activity.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {
    CMD_START_ADDR = 2'd0,
    CMD_READ_NACK  = 2'd1,
    CMD_STOP       = 2'd2
  } mst_cmd_e;

  typedef struct packed {
    logic clrAddr;
    logic incAddr;
    logic capLines;
  } scan_strobe_t;
endpackage

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned ADDR_STEP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  scan_strobe_t      stb,
  input  logic              sdaIn,
  input  logic              sclIn,
  output logic [ADDR_W-1:0] probeAddr,
  output logic              lastAddr,
  output logic [1:0]        lineLevels
);
  localparam int unsigned LastAddrVal = (1 << ADDR_W) - ADDR_STEP;
  localparam logic [ADDR_W-1:0] LastAddr = LastAddrVal[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] StepVal  = ADDR_STEP[ADDR_W-1:0];

  logic [ADDR_W-1:0] addrQ;
  logic [1:0]        levelsQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      levelsQ <= 2'b00;
    end else begin
      if (stb.clrAddr)       addrQ <= '0;
      else if (stb.incAddr)  addrQ <= addrQ + StepVal;
      if (stb.capLines)      levelsQ <= {sdaIn, sclIn};
    end
  end

  assign probeAddr  = addrQ;
  assign lastAddr   = (addrQ == LastAddr);
  assign lineLevels = levelsQ;

  a_r3_no_wrap_step: assert property (@(posedge clk) disable iff (!rstN)
    stb.incAddr |-> !lastAddr);
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  input  logic         busIdle,
  input  logic         lastAddr,
  input  logic         mstCmdReady,
  input  logic         mstRspValid,
  input  logic         mstRspErr,
  input  logic         mstRspTimeout,
  input  logic         foundReady,
  output scan_strobe_t stb,
  output logic         mstCmdValid,
  output mst_cmd_e     mstCmd,
  output logic         portLock,
  output logic         wdKick,
  output logic         foundValid,
  output logic         busyAbort,
  output logic         scanDone
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_KICK, ST_SEND_START, ST_WAIT_START, ST_SEND_READ,
    ST_WAIT_READ, ST_SEND_STOP, ST_WAIT_STOP, ST_REPORT, ST_NEXT, ST_DONE
  } state_e;

  state_e stateQ, stateD;
  logic   abortQ, abortD;
  logic   rspBad;

  assign rspBad = mstRspErr | mstRspTimeout;

  always_comb begin
    stateD = stateQ;
    abortD = 1'b0;
    stb    = '0;
    unique case (stateQ)
      ST_IDLE: if (startReq) begin
        if (busIdle) begin
          stb.clrAddr = 1'b1;
          stateD      = ST_KICK;
        end else begin
          stb.capLines = 1'b1;
          abortD       = 1'b1;
        end
      end
      ST_KICK:       stateD = ST_SEND_START;
      ST_SEND_START: if (mstCmdReady) stateD = ST_WAIT_START;
      ST_WAIT_START: if (mstRspValid) stateD = rspBad ? ST_NEXT : ST_SEND_READ;
      ST_SEND_READ:  if (mstCmdReady) stateD = ST_WAIT_READ;
      ST_WAIT_READ:  if (mstRspValid) stateD = rspBad ? ST_NEXT : ST_SEND_STOP;
      ST_SEND_STOP:  if (mstCmdReady) stateD = ST_WAIT_STOP;
      ST_WAIT_STOP:  if (mstRspValid) stateD = rspBad ? ST_NEXT : ST_REPORT;
      ST_REPORT:     if (foundReady)  stateD = ST_NEXT;
      ST_NEXT: begin
        if (lastAddr) stateD = ST_DONE;
        else begin
          stb.incAddr = 1'b1;
          stateD      = ST_KICK;
        end
      end
      ST_DONE:       stateD = ST_IDLE;
      default:       stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      abortQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      abortQ <= abortD;
    end
  end

  always_comb begin
    mstCmdValid = 1'b0;
    mstCmd      = CMD_START_ADDR;
    unique case (stateQ)
      ST_SEND_START: mstCmdValid = 1'b1;
      ST_SEND_READ: begin
        mstCmdValid = 1'b1;
        mstCmd      = CMD_READ_NACK;
      end
      ST_SEND_STOP: begin
        mstCmdValid = 1'b1;
        mstCmd      = CMD_STOP;
      end
      default: ;
    endcase
  end

  assign portLock   = (stateQ != ST_IDLE);
  assign wdKick     = (stateQ == ST_KICK);
  assign foundValid = (stateQ == ST_REPORT);
  assign scanDone   = (stateQ == ST_DONE);
  assign busyAbort  = abortQ;

  a_r1_abort_no_lock: assert property (@(posedge clk) disable iff (!rstN)
    busyAbort |-> !portLock && !mstCmdValid);
  a_r7_cmd_under_lock: assert property (@(posedge clk) disable iff (!rstN)
    mstCmdValid |-> portLock);
  a_r8_no_cmd_while_found: assert property (@(posedge clk) disable iff (!rstN)
    foundValid |-> !mstCmdValid);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |=> !scanDone && !portLock);
  a_r6_kick_then_start: assert property (@(posedge clk) disable iff (!rstN)
    wdKick |=> mstCmdValid && (mstCmd == CMD_START_ADDR));
endmodule

// File: rtl/i2c_addr_scanner.sv
module i2c_addr_scanner
  import scan_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned ADDR_STEP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              startReq,
  output logic              mstCmdValid,
  input  logic              mstCmdReady,
  output logic [1:0]        mstCmd,
  output logic [ADDR_W-1:0] mstAddr,
  input  logic              mstRspValid,
  input  logic              mstRspErr,
  input  logic              mstRspTimeout,
  output logic              portLock,
  output logic              wdKick,
  output logic              foundValid,
  input  logic              foundReady,
  output logic [ADDR_W-1:0] foundAddr,
  output logic              busyAbort,
  output logic [1:0]        lineLevels,
  output logic              scanDone
);
  scan_strobe_t      stb;
  mst_cmd_e          cmdKind;
  logic [ADDR_W-1:0] probeAddr;
  logic              lastAddr;

  scan_ctrl u_ctrl (
    .clk, .rstN, .startReq,
    .busIdle(sdaIn & sclIn),
    .lastAddr, .mstCmdReady, .mstRspValid, .mstRspErr, .mstRspTimeout,
    .foundReady, .stb, .mstCmdValid,
    .mstCmd(cmdKind),
    .portLock, .wdKick, .foundValid, .busyAbort, .scanDone
  );

  scan_datapath #(.ADDR_W(ADDR_W), .ADDR_STEP(ADDR_STEP)) u_dp (
    .clk, .rstN, .stb, .sdaIn, .sclIn, .probeAddr, .lastAddr, .lineLevels
  );

  assign mstCmd    = cmdKind;
  assign mstAddr   = {probeAddr[ADDR_W-1:1], 1'b1};
  assign foundAddr = probeAddr;

  a_r8_found_held: assert property (@(posedge clk) disable iff (!rstN)
    foundValid && !foundReady |=> foundValid && $stable(foundAddr));
endmodule

// File: tb/i2c_addr_scanner_tb.sv
module i2c_addr_scanner_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclIn = 1'b1, sdaIn = 1'b1, startReq = 1'b0;
  logic mstCmdReady = 1'b0, mstRspValid = 1'b0, mstRspErr = 1'b0, mstRspTimeout = 1'b0;
  logic foundReady = 1'b0;
  logic mstCmdValid, portLock, wdKick, foundValid, busyAbort, scanDone;
  logic [1:0] mstCmd, lineLevels;
  logic [7:0] mstAddr, foundAddr;

  int nChecks = 0, nFails = 0;

  always #4 clk = ~clk;

  i2c_addr_scanner u_dut (
    .clk, .rstN, .sclIn, .sdaIn, .startReq, .mstCmdValid, .mstCmdReady,
    .mstCmd, .mstAddr, .mstRspValid, .mstRspErr, .mstRspTimeout, .portLock,
    .wdKick, .foundValid, .foundReady, .foundAddr, .busyAbort, .lineLevels,
    .scanDone
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit devAnswers(input int m, input int a);
    if (m == 0) return a == 0 || a == 16 || a == 48 || a == 80 || a == 96 ||
                       a == 160 || a == 254;
    return (a % 8) != 2;
  endfunction

  task automatic refuse(input logic sda, input logic scl);
    @(negedge clk);
    sdaIn = sda; sclIn = scl; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk(busyAbort == 1'b1, "R1", "busyAbort pulse", busyAbort, 1);
    chk(lineLevels == {sda, scl}, "R2", "lineLevels", lineLevels, {sda, scl});
    chk(portLock == 1'b0 && mstCmdValid == 1'b0, "R1", "quiet on refusal",
        {portLock, mstCmdValid}, 0);
    sdaIn = 1'b1; sclIn = 1'b1;
    @(negedge clk);
    chk(busyAbort == 1'b0, "R1", "busyAbort single cycle", busyAbort, 0);
    chk(lineLevels == {sda, scl}, "R2", "lineLevels held", lineLevels, {sda, scl});
    chk(portLock == 1'b0 && mstCmdValid == 1'b0, "R1", "no activity after refusal",
        {portLock, mstCmdValid}, 0);
  endtask

  task automatic runScan(input int m);
    int expAddr = 0, phase = 0, cd = 0, kicks = 0, cyc = 0, rspPhase = 0;
    int expQ[$];
    bit done = 1'b0, pendErr = 1'b0, pendTo = 1'b0, prevHold = 1'b0;
    logic [7:0] prevFound = 8'h00;
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    while (!done && cyc < 20000) begin
      cyc++;
      chk(portLock == 1'b1, "R7", "lock during scan", portLock, 1);
      if (wdKick) kicks++;
      if (prevHold)
        chk(foundValid && foundAddr == prevFound, "R8", "found held", foundAddr, prevFound);
      if (foundValid)
        chk(mstCmdValid == 1'b0, "R8", "no cmd while found pending", mstCmdValid, 0);
      mstRspValid = 1'b0; mstRspErr = 1'b0; mstRspTimeout = 1'b0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin
          mstRspValid = 1'b1; mstRspErr = pendErr; mstRspTimeout = pendTo;
          if (pendErr || pendTo) begin expAddr += 2; phase = 0; end
          else if (rspPhase == 2) begin expQ.push_back(expAddr); phase = 0; end
          else phase = rspPhase + 1;
        end
      end
      mstCmdReady = (m == 1) ? 1'b1 : ((cyc % 3) != 1);
      foundReady  = (m == 1) ? 1'b1 : ((cyc % 4) == 0);
      if (mstCmdValid && mstCmdReady) begin
        chk(mstCmd == phase[1:0], "R4", "command order", mstCmd, phase);
        chk(mstAddr == 8'(expAddr | 1), "R3", "probe address", mstAddr, expAddr | 1);
        if (phase == 0)
          chk(kicks == expAddr / 2 + 1, "R6", "kick before start", kicks, expAddr / 2 + 1);
        rspPhase = phase;
        pendErr = (phase == 0 && !devAnswers(m, expAddr)) ||
                  (phase == 2 && m == 0 && expAddr == 96);
        pendTo  = (phase == 1 && m == 0 && expAddr == 48);
        cd = 2;
        phase = 3;
      end
      if (foundValid && foundReady) begin
        if (expQ.size() == 0) chk(1'b0, "R5", "unexpected found", foundAddr, 0);
        else begin
          chk(foundAddr == 8'(expQ[0]), "R5", "found address", foundAddr, expQ[0]);
          void'(expQ.pop_front());
        end
        expAddr += 2;
      end
      prevHold  = foundValid && !foundReady;
      prevFound = foundAddr;
      if (scanDone) done = 1'b1;
      @(negedge clk);
    end
    chk(done, "R9", "scan finished", done, 1);
    chk(expAddr == 256, "R3", "all addresses probed", expAddr, 256);
    chk(expQ.size() == 0, "R5", "all found reported", expQ.size(), 0);
    chk(kicks == 128, "R6", "kick count", kicks, 128);
    chk(scanDone == 1'b0, "R9", "done single pulse", scanDone, 0);
    chk(portLock == 1'b0, "R7", "lock released", portLock, 0);
    mstCmdReady = 1'b0; foundReady = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk({mstCmdValid, portLock, wdKick, foundValid, busyAbort, scanDone} == 6'b0,
        "R10", "control outputs after reset",
        {mstCmdValid, portLock, wdKick, foundValid, busyAbort, scanDone}, 0);
    chk(lineLevels == 2'b00, "R10", "lineLevels after reset", lineLevels, 0);
    refuse(1'b0, 1'b1);
    refuse(1'b1, 1'b0);
    refuse(1'b0, 1'b0);
    runScan(0);
    runScan(1);
    refuse(1'b1, 1'b0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #1000000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule